// File: doc/BRIEF.md
# Card Slot Reset and Clock-Enable Sequencer

This block holds a card slot in reset while its supply rails come up and releases it only when both the local rails and the host agree. It watches three per-rail "within tolerance" flags. While any flag is low it pulls a shared open-drain clock-enable wire low. Once every rail has been good for a programmed number of cycles, it lets go of the wire, and an external pull-up raises it. The host can hold the same wire low to delay the start.

A two-flop synchronizer samples the level on the wire. A rising edge on the synchronized level starts a release timer, and the active-low slot reset deasserts when that timer completes. A rail failure, a falling wire or the host's own active-low system reset brings the slot reset low again. After a rail failure the whole sequence repeats from the start once the rails recover. Both intervals are parameters given in clock cycles: about 100 µs for the wire release and about 20 ms for the reset release at the default clock.

Top module: `slot_reset_seq`

## Requirements
- R1: During and directly after the synchronous reset, `slot_rst_n` is 0 and `clken_pull` is 1. A value of 1 on `clken_pull` means the wire is driven low.
- R2: `clken_pull` stays 1 while any bit of `rail_ok` is 0. Once all bits are 1, `clken_pull` drops to 0 exactly PG_DELAY clock edges later.
- R3: When any rail flag goes to 0, `clken_pull` returns to 1 and `slot_rst_n` goes to 0 on the next clock edge.
- R4: `slot_rst_n` rises exactly RELEASE_CYCLES+4 edges after the wire rises: 2 synchronizer edges, 1 edge-detect edge, RELEASE_CYCLES timer edges and 1 output edge. It does not rise one edge earlier.
- R5: While the host holds the wire low after `clken_pull` has dropped, the timer does not start and `slot_rst_n` stays 0. Timing begins when the wire is released.
- R6: A low level on the wire, whether the timer is running or has finished, clears the timer. If the reset was already released, `slot_rst_n` goes to 0 four edges after the wire falls. The next rising edge on the wire restarts a full RELEASE_CYCLES count.
- R7: While `host_rst_n` is 0, `slot_rst_n` is 0 from the next edge on, whatever the rail state.
- R8: When `host_rst_n` returns to 1, `slot_rst_n` rises on the next edge only if the rails are good and the timer has already finished. Otherwise it rises when the sequence completes.
- R9: When the rails recover after a failure, the full sequence repeats: a PG_DELAY wait, then release of the wire, then RELEASE_CYCLES+4 edges to reset release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| rail_ok | input | NUM_RAILS | Per-rail output-within-tolerance flags, 1 = good |
| host_rst_n | input | 1 | Host system reset, active low, synchronous to clk |
| clken_sense | input | 1 | Sensed level of the shared clock-enable wire |
| slot_rst_n | output | 1 | Slot reset, active low, registered |
| clken_pull | output | 1 | 1 = drive the shared wire low, 0 = release it |

## Verification
Each result has a fixed latency counted in edges from the stimulus:
- Rail loss and host reset appear after 1 edge.
- Release of the wire appears after PG_DELAY edges.
- A falling wire reasserts reset after 4 edges.
- Reset release comes RELEASE_CYCLES+4 edges after the wire rises.

The driver stamps each expected value with its target cycle, counted from the current cycle, and queues it. The monitor compares it on the falling clock edge of exactly that cycle. The release is always paired with a check one cycle earlier, so a sequence that releases early or late is reported.

// File: rtl/slot_seq_pkg.sv
package slot_seq_pkg;

    typedef enum logic [1:0] {
        TMR_IDLE = 2'd0,
        TMR_RUN  = 2'd1,
        TMR_DONE = 2'd2
    } tmr_state_e;

    typedef struct packed {
        logic level;
        logic rise;
    } wire_obs_t;

    function automatic int cnt_width(input int limit);
        return (limit < 2) ? 1 : $clog2(limit);
    endfunction

endpackage

// File: rtl/slot_seq_pgood.sv
module slot_seq_pgood
    import slot_seq_pkg::*;
#(
    parameter int NUM_RAILS = 3,
    parameter int PG_DELAY  = 25000
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_RAILS-1:0] rail_ok,
    output logic                 all_ok,
    output logic                 pull
);
    localparam int CW = cnt_width(PG_DELAY);

    logic [CW-1:0] cnt_q;
    logic          pull_q;

    assign all_ok = &rail_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            pull_q <= 1'b1;
        end else if (!all_ok) begin
            cnt_q  <= '0;
            pull_q <= 1'b1;
        end else if (pull_q) begin
            if (cnt_q == CW'(PG_DELAY - 1)) begin
                pull_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign pull = pull_q;

endmodule

// File: rtl/slot_seq_sync.sv
module slot_seq_sync
    import slot_seq_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      async_in,
    output wire_obs_t obs
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_in};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    always_comb begin
        obs.level = chain_q[STAGES-1];
        obs.rise  = chain_q[STAGES-1] & ~prev_q;
    end

endmodule

// File: rtl/slot_seq_timer.sv
module slot_seq_timer
    import slot_seq_pkg::*;
#(
    parameter int RELEASE_CYCLES = 5000000
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic start,
    output logic done
);
    localparam int CW = cnt_width(RELEASE_CYCLES);

    tmr_state_e    state_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            state_q <= TMR_IDLE;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                TMR_IDLE: begin
                    if (start) begin
                        state_q <= TMR_RUN;
                        cnt_q   <= '0;
                    end
                end
                TMR_RUN: begin
                    if (cnt_q == CW'(RELEASE_CYCLES - 1)) begin
                        state_q <= TMR_DONE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= TMR_DONE;
            endcase
        end
    end

    assign done = (state_q == TMR_DONE);

endmodule

// File: rtl/slot_reset_seq.sv
module slot_reset_seq
    import slot_seq_pkg::*;
#(
    parameter int NUM_RAILS      = 3,
    parameter int PG_DELAY       = 25000,
    parameter int RELEASE_CYCLES = 5000000,
    parameter int SYNC_STAGES    = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_RAILS-1:0] rail_ok,
    input  logic                 host_rst_n,
    input  logic                 clken_sense,
    output logic                 slot_rst_n,
    output logic                 clken_pull
);
    logic      all_ok;
    logic      pull;
    wire_obs_t obs;
    logic      tmr_done;
    logic      slot_q;

    slot_seq_pgood #(
        .NUM_RAILS (NUM_RAILS),
        .PG_DELAY  (PG_DELAY)
    ) pgood_i (
        .clk     (clk),
        .rst     (rst),
        .rail_ok (rail_ok),
        .all_ok  (all_ok),
        .pull    (pull)
    );

    slot_seq_sync #(
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk      (clk),
        .rst      (rst),
        .async_in (clken_sense),
        .obs      (obs)
    );

    slot_seq_timer #(
        .RELEASE_CYCLES (RELEASE_CYCLES)
    ) timer_i (
        .clk   (clk),
        .rst   (rst),
        .clear (~all_ok | ~obs.level),
        .start (obs.rise),
        .done  (tmr_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= 1'b0;
        end else begin
            slot_q <= host_rst_n & all_ok & tmr_done;
        end
    end

    assign slot_rst_n = slot_q;
    assign clken_pull = pull;

endmodule

// File: rtl/slot_reset_seq_chk.sv
module slot_reset_seq_chk #(
    parameter int NUM_RAILS = 3
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NUM_RAILS-1:0] rail_ok,
    input logic                 host_rst_n,
    input logic                 clken_sense,
    input logic                 slot_rst_n,
    input logic                 clken_pull
);
    // R3
    rail_loss_chk: assert property (@(posedge clk) disable iff (rst)
        !(&rail_ok) |=> (!slot_rst_n && clken_pull));

    // R7
    host_rst_chk: assert property (@(posedge clk) disable iff (rst)
        !host_rst_n |=> !slot_rst_n);

    // R2
    pull_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(clken_pull) |-> $past(&rail_ok));

    // R4
    release_wire_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(slot_rst_n) |-> $past(clken_sense, 3));

    // R3
    released_pull_chk: assert property (@(posedge clk) disable iff (rst)
        slot_rst_n |-> !clken_pull);

endmodule

bind slot_reset_seq slot_reset_seq_chk #(.NUM_RAILS(NUM_RAILS)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .rail_ok     (rail_ok),
    .host_rst_n  (host_rst_n),
    .clken_sense (clken_sense),
    .slot_rst_n  (slot_rst_n),
    .clken_pull  (clken_pull)
);

// File: tb/slot_reset_seq_tb_top.sv
module slot_reset_seq_tb_top;
    localparam int D   = 4;
    localparam int REL = 20;

    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] rails;
    logic       host_rst_n;
    logic       host_hold;
    logic       clken_sense;
    logic       slot_rst_n;
    logic       clken_pull;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    typedef struct {
        int    at;
        logic  exp_rst;
        logic  exp_pull;
        string tag;
    } sb_item_t;

    sb_item_t sb[$];

    always #2 clk = ~clk;

    assign clken_sense = ~(clken_pull | host_hold);

    slot_reset_seq #(
        .NUM_RAILS      (3),
        .PG_DELAY       (D),
        .RELEASE_CYCLES (REL),
        .SYNC_STAGES    (2)
    ) dut_i (
        .clk         (clk),
        .rst         (rst),
        .rail_ok     (rails),
        .host_rst_n  (host_rst_n),
        .clken_sense (clken_sense),
        .slot_rst_n  (slot_rst_n),
        .clken_pull  (clken_pull)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: compare every item due in this cycle
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].at == cyc) begin
                checks++;
                if (slot_rst_n !== sb[i].exp_rst || clken_pull !== sb[i].exp_pull) begin
                    errors++;
                    $display("FAIL %s cyc=%0d: slot_rst_n=%b clken_pull=%b expected %b %b",
                             sb[i].tag, cyc, slot_rst_n, clken_pull,
                             sb[i].exp_rst, sb[i].exp_pull);
                end
                sb.delete(i);
            end
        end
    end

    task automatic expect_after(input int k, input logic r, input logic p, input string tag);
        sb.push_back('{cyc + k, r, p, tag});
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic power_up(input string tag);
        expect_after(D - 1, 1'b0, 1'b1, {tag, " R2 pull held"});
        expect_after(D, 1'b0, 1'b0, {tag, " R2 pull released"});
        expect_after(D + REL + 3, 1'b0, 1'b0, {tag, " R4 not early"});
        expect_after(D + REL + 4, 1'b1, 1'b0, {tag, " R4 release"});
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(negedge clk);
        if (!done_flag) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run hung, actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        rst = 1'b1; rails = 3'b000; host_rst_n = 1'b1; host_hold = 1'b0;
        wait_n(1);
        expect_after(1, 1'b0, 1'b1, "R1 in reset");
        wait_n(3);
        rst = 1'b0;
        expect_after(2, 1'b0, 1'b1, "R1 after reset");

        // partial rails keep the wire pulled low
        rails = 3'b011;
        expect_after(30, 1'b0, 1'b1, "R2 partial rails");
        wait_n(31);

        rails = 3'b111;
        power_up("first");
        wait_n(D + REL + 6);

        // rail loss, then recovery repeats the sequence
        rails = 3'b101;
        expect_after(1, 1'b0, 1'b1, "R3 rail loss");
        wait_n(6);
        rails = 3'b111;
        power_up("R9 repeat");
        wait_n(D + REL + 6);

        // host reset after completion
        host_rst_n = 1'b0;
        expect_after(1, 1'b0, 1'b0, "R7 host reset");
        wait_n(10);
        host_rst_n = 1'b1;
        expect_after(1, 1'b1, 1'b0, "R8 immediate release");
        wait_n(3);

        // host holds the wire low
        rails = 3'b110;
        expect_after(1, 1'b0, 1'b1, "R3 rail loss 2");
        wait_n(4);
        host_hold = 1'b1;
        rails = 3'b111;
        expect_after(D, 1'b0, 1'b0, "R5 pull released");
        expect_after(60, 1'b0, 1'b0, "R5 held off");
        wait_n(61);
        host_hold = 1'b0;
        expect_after(REL + 3, 1'b0, 1'b0, "R5 not early");
        expect_after(REL + 4, 1'b1, 1'b0, "R5 release");
        wait_n(REL + 6);

        // wire falls after release, then falls mid-timer
        host_hold = 1'b1;
        expect_after(3, 1'b1, 1'b0, "R6 before reassert");
        expect_after(4, 1'b0, 1'b0, "R6 reassert");
        wait_n(8);
        host_hold = 1'b0;
        wait_n(10);
        host_hold = 1'b1;
        wait_n(5);
        host_hold = 1'b0;
        expect_after(REL + 3, 1'b0, 1'b0, "R6 restart not early");
        expect_after(REL + 4, 1'b1, 1'b0, "R6 restart release");
        wait_n(REL + 6);

        // host reset released before the sequence completes
        rails = 3'b011;
        wait_n(3);
        host_rst_n = 1'b0;
        rails = 3'b111;
        wait_n(10);
        host_rst_n = 1'b1;
        expect_after(1, 1'b0, 1'b0, "R8 waits for sequence");
        expect_after(D + REL + 3 - 10, 1'b0, 1'b0, "R8 not early");
        expect_after(D + REL + 4 - 10, 1'b1, 1'b0, "R8 release after sequence");
        wait_n(D + REL);

        wait_n(3);
        if (sb.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL scoreboard: %0d items left, expected 0", sb.size());
        end
        done_flag = 1;
        finish_run();
    end

endmodule